// File: doc/BRIEF.md
# USB event status and suspend detector

This block gathers the events a simple full-speed USB device function has to report to its controller and keeps each one as a sticky flag. Three flags come from single-cycle transfer-done pulses of the endpoint logic: endpoint 0 received data, endpoint 0 sent data, and endpoint 1 sent data. A fourth flag records that resume signalling was seen on the bus. The fifth flag is raised by a built-in idle timer. The timer counts timebase ticks, typically one per microsecond. Any bus activity restarts the count. Once the idle time passes the threshold (3 ms by default), the timer flags a global suspend.

Software reaches the block through a small register port with a write strobe, a register select, write data and a combinational read mux. Status flags are cleared by writing a one to them. A five-bit enable register masks the flags onto a single interrupt line. A seven-bit device address register drives the address used by the serial engine.

The idle timer is a two-state machine. `ST_COUNTING` counts ticks while the bus is quiet. On a tick that arrives with the count already at the limit and no bus activity, it raises the suspend event and moves to `ST_SUSPENDED`. `ST_SUSPENDED` ignores ticks. Bus activity moves it back to `ST_COUNTING` with the count at zero. Bus activity in `ST_COUNTING` also restarts the count.

Top module: `usb_evt_status`

## Requirements
- R1: After reset, all status flags, the enable register, the device address, `irq` and every readable register are zero.
- R2: A pulse on `ep0_rx_done`, `ep0_tx_done` or `ep1_tx_done` sets status bit 0, 1 or 2 respectively, visible from the clock edge that samples the pulse.
- R3: A pulse on `resume_det` sets status bit 4.
- R4: With `bus_active` low, status bit 3 (suspend) sets at the clock edge that samples tick number IDLE_TICKS+1 counted since the last activity or reset. It is still clear after IDLE_TICKS ticks.
- R5: Any cycle with `bus_active` high restarts the idle count. After suspend has been flagged it is not flagged again until activity has occurred, even if software clears the flag.
- R6: A write to select 0 (status) clears every status bit whose write-data bit is 1. Bits written 0 keep their value. Status bits 7..5 always read 0.
- R7: When a hardware set event and a software clear of the same status bit fall in the same cycle, the bit ends up set.
- R8: A write to select 2 loads `wr_data[6:0]` into the device address, which appears on `dev_addr` and reads back at select 2 with bit 7 as 0.
- R9: A write to select 1 loads `wr_data[4:0]` into the enable register, which reads back at select 1. `irq` is high exactly when some status bit and its enable bit are both 1.
- R10: Select 3 reads as zero, and writes to select 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Idle timebase tick, one cycle wide |
| bus_active | input | 1 | Bus activity seen this cycle |
| resume_det | input | 1 | Resume signalling detected pulse |
| ep0_rx_done | input | 1 | Endpoint 0 data received pulse |
| ep0_tx_done | input | 1 | Endpoint 0 data sent pulse |
| ep1_tx_done | input | 1 | Endpoint 1 data sent pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes (0 status, 1 enable, 2 address, 3 none) |
| wr_data | input | 8 | Register write data |
| rd_sel | input | 2 | Register select for the read mux |
| rd_data | output | 8 | Read data for `rd_sel` |
| irq | output | 1 | Interrupt, OR of enabled status flags |
| dev_addr | output | 7 | Device address |

## Verification
The assertions assume that the event inputs are sampled only at clock edges. They also assume that the suspend threshold is at least one tick, so a restart by `bus_active` cannot lead straight into a suspend event. The interrupt-hold property further assumes that the enable and status registers change only through the write port. The stimulus drives every input shortly after the rising edge. It stays with the default select encoding and never writes to the block during reset. The random phase draws each event independently, so writes that clear a bit often land in the same cycle as the set event for that bit. The bench shortens the threshold so that many idle periods, restarts and suspend events fit in the run.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
    localparam int REG_W  = 8;
    localparam int STAT_W = 5;

    localparam int BIT_EP0_RX = 0;
    localparam int BIT_EP0_TX = 1;
    localparam int BIT_EP1_TX = 2;
    localparam int BIT_SUSP   = 3;
    localparam int BIT_RESUME = 4;

    localparam logic [1:0] SEL_STAT = 2'd0;
    localparam logic [1:0] SEL_EN   = 2'd1;
    localparam logic [1:0] SEL_ADDR = 2'd2;
    localparam logic [1:0] SEL_NONE = 2'd3;

    typedef enum logic {
        ST_COUNTING  = 1'b0,
        ST_SUSPENDED = 1'b1
    } idle_state_t;
endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer
    import usb_evt_pkg::*;
#(
    parameter int IDLE_TICKS = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bus_active,
    output logic suspend_evt
);
    localparam int CNT_W = $clog2(IDLE_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_TICKS);

    idle_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic at_limit;

    assign at_limit = (cnt_q == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNTING;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_COUNTING: begin
                if (bus_active) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (at_limit) begin
                        state_d = ST_SUSPENDED;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_SUSPENDED: begin
                if (bus_active) begin
                    state_d = ST_COUNTING;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_COUNTING;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        suspend_evt = 1'b0;
        unique case (state_q)
            ST_COUNTING:  suspend_evt = !bus_active && tick && at_limit;
            ST_SUSPENDED: suspend_evt = 1'b0;
            default:      suspend_evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/usb_sticky_w1c.sv
module usb_sticky_w1c #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags_q
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                flags_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                flags_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/usb_evt_status.sv
module usb_evt_status
    import usb_evt_pkg::*;
#(
    parameter int IDLE_TICKS = 3000,
    parameter int ADDR_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_active,
    input  logic              resume_det,
    input  logic              ep0_rx_done,
    input  logic              ep0_tx_done,
    input  logic              ep1_tx_done,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [1:0]        rd_sel,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq,
    output logic [ADDR_W-1:0] dev_addr
);
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] en_q;
    logic [ADDR_W-1:0] addr_q;
    logic              suspend_evt;

    usb_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .bus_active  (bus_active),
        .suspend_evt (suspend_evt)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[BIT_EP0_RX] = ep0_rx_done;
        set_vec[BIT_EP0_TX] = ep0_tx_done;
        set_vec[BIT_EP1_TX] = ep1_tx_done;
        set_vec[BIT_SUSP]   = suspend_evt;
        set_vec[BIT_RESUME] = resume_det;
    end

    assign clr_vec = (wr_en && wr_sel == SEL_STAT) ? wr_data[STAT_W-1:0] : '0;

    usb_sticky_w1c #(.W(STAT_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags_q (stat_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            addr_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_EN)   en_q   <= wr_data[STAT_W-1:0];
            if (wr_sel == SEL_ADDR) addr_q <= wr_data[ADDR_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_STAT: rd_data[STAT_W-1:0] = stat_q;
            SEL_EN:   rd_data[STAT_W-1:0] = en_q;
            SEL_ADDR: rd_data[ADDR_W-1:0] = addr_q;
            SEL_NONE: rd_data = '0;
            default:  rd_data = '0;
        endcase
    end

    assign irq      = |(stat_q & en_q);
    assign dev_addr = addr_q;
endmodule

// File: rtl/usb_evt_status_chk.sv
module usb_evt_status_chk
    import usb_evt_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_active,
    input logic              resume_det,
    input logic              ep0_rx_done,
    input logic              ep0_tx_done,
    input logic              ep1_tx_done,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [REG_W-1:0]  wr_data,
    input logic              irq,
    input logic [ADDR_W-1:0] dev_addr,
    input logic [STAT_W-1:0] stat_q
);
    // R1
    always_comb begin
        if (!rst_n) begin
            reset_clear_chk: assert (dev_addr == '0 && !irq && stat_q == '0);
        end
    end

    // R2 R7
    ep0_rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ep0_rx_done |=> stat_q[BIT_EP0_RX]);

    // R2 R7
    ep0_tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ep0_tx_done |=> stat_q[BIT_EP0_TX]);

    // R2 R7
    ep1_tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ep1_tx_done |=> stat_q[BIT_EP1_TX]);

    // R3
    resume_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_det |=> stat_q[BIT_RESUME]);

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_STAT && wr_data[BIT_EP0_RX] && !ep0_rx_done)
        |=> !stat_q[BIT_EP0_RX]);

    // R6
    w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[BIT_EP0_TX] && !(wr_en && wr_sel == SEL_STAT && wr_data[BIT_EP0_TX]))
        |=> stat_q[BIT_EP0_TX]);

    // R5
    no_susp_after_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active |=> !$rose(stat_q[BIT_SUSP]));

    // R8
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_ADDR) |=> dev_addr == $past(wr_data[ADDR_W-1:0]));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq);
endmodule

bind usb_evt_status usb_evt_status_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_usb_evt_status.sv
module sim_usb_evt_status;
    localparam int CLK_PERIOD = 10;
    localparam int IDLE = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_active = 1'b0;
    logic       resume_det = 1'b0;
    logic       ep0_rx_done = 1'b0;
    logic       ep0_tx_done = 1'b0;
    logic       ep1_tx_done = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       irq;
    logic [6:0] dev_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [7:0] m_stat = 8'd0;
    logic [7:0] m_en = 8'd0;
    logic [7:0] m_addr = 8'd0;
    int         m_cnt = 0;
    bit         m_armed = 1'b1;

    usb_evt_status #(.IDLE_TICKS(IDLE), .ADDR_W(7)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_active(bus_active),
        .resume_det(resume_det), .ep0_rx_done(ep0_rx_done),
        .ep0_tx_done(ep0_tx_done), .ep1_tx_done(ep1_tx_done),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .dev_addr(dev_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = 0; m_en = 0; m_addr = 0; m_cnt = 0; m_armed = 1'b1;
        end else begin
            logic [7:0] setb;
            logic [7:0] clrb;
            setb = 8'd0;
            if (ep0_rx_done) setb[0] = 1'b1;
            if (ep0_tx_done) setb[1] = 1'b1;
            if (ep1_tx_done) setb[2] = 1'b1;
            if (resume_det)  setb[4] = 1'b1;
            if (bus_active) begin
                m_cnt = 0; m_armed = 1'b1;
            end else if (tick && m_armed) begin
                if (m_cnt == IDLE) begin
                    setb[3] = 1'b1; m_armed = 1'b0;
                end else begin
                    m_cnt++;
                end
            end
            clrb = (wr_en && wr_sel == 2'd0) ? (wr_data & 8'h1F) : 8'd0;
            m_stat = (m_stat & ~clrb) | setb;
            if (wr_en && wr_sel == 2'd1) m_en = wr_data & 8'h1F;
            if (wr_en && wr_sel == 2'd2) m_addr = wr_data & 8'h7F;
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        logic [7:0] exp_rd;
        case (rd_sel)
            2'd0: exp_rd = m_stat;
            2'd1: exp_rd = m_en;
            2'd2: exp_rd = m_addr;
            default: exp_rd = 8'd0;
        endcase
        if (!finished) begin
            chk("R6/R10 model rd_data", int'(rd_data), int'(exp_rd));
            chk("R9 model irq", int'(irq), int'(|(m_stat & m_en)));
            chk("R8 model dev_addr", int'(dev_addr), int'(m_addr));
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic look();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = 8'd0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) step();
        rd_sel = 2'd0; look(); chk("R1 status after reset", rd_data, 0);
        chk("R1 irq after reset", irq, 0);
        step(); rd_sel = 2'd1; look(); chk("R1 enable after reset", rd_data, 0);
        step(); rd_sel = 2'd2; look(); chk("R1 address after reset", rd_data, 0);
        chk("R1 dev_addr after reset", dev_addr, 0);
        step(); rst_n = 1'b1; rd_sel = 2'd0;
        step();

        // R2 endpoint flags
        ep0_rx_done = 1'b1; step(); ep0_rx_done = 1'b0; look();
        chk("R2 ep0 rx sets bit0", rd_data, 8'h01);
        step();
        ep0_tx_done = 1'b1; step(); ep0_tx_done = 1'b0; look();
        chk("R2 ep0 tx sets bit1", rd_data, 8'h03);
        step();
        ep1_tx_done = 1'b1; step(); ep1_tx_done = 1'b0; look();
        chk("R2 ep1 tx sets bit2", rd_data, 8'h07);
        step();
        // R3 resume flag
        resume_det = 1'b1; step(); resume_det = 1'b0; look();
        chk("R3 resume sets bit4", rd_data, 8'h17);
        chk("R9 irq masked with enables zero", irq, 0);
        step();

        // R9 enable and interrupt
        wr(2'd1, 8'hE2); rd_sel = 2'd1; look();
        chk("R9 enable readback", rd_data, 8'h02);
        chk("R9 irq with enabled flag", irq, 1);
        step(); rd_sel = 2'd0;

        // R6 write-one-to-clear
        wr(2'd0, 8'h01); look(); chk("R6 clear bit0", rd_data, 8'h16);
        step();
        wr(2'd0, 8'h00); look(); chk("R6 write zero keeps flags", rd_data, 8'h16);
        step();
        wr(2'd0, 8'hE0); look(); chk("R6 upper bits read zero", rd_data, 8'h16);
        step();

        // R7 set wins over clear in the same cycle
        ep1_tx_done = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h04;
        step(); ep1_tx_done = 1'b0; wr_en = 1'b0; wr_data = 8'h00; look();
        chk("R7 set wins over clear", rd_data, 8'h16);
        step();
        wr(2'd0, 8'h1F); look(); chk("R6 clear all", rd_data, 8'h00);
        chk("R9 irq drops when flag cleared", irq, 0);
        step();

        // R8 device address
        wr(2'd2, 8'hFF); rd_sel = 2'd2; look();
        chk("R8 address readback bit7 zero", rd_data, 8'h7F);
        chk("R8 dev_addr output", dev_addr, 7'h7F);
        step();
        wr(2'd2, 8'h35); look(); chk("R8 address rewrite", dev_addr, 7'h35);
        step();

        // R10 select 3
        wr(2'd3, 8'hFF); rd_sel = 2'd3; look();
        chk("R10 select 3 reads zero", rd_data, 0);
        step(); rd_sel = 2'd2; look();
        chk("R10 select 3 write leaves address", rd_data, 8'h35);
        step(); rd_sel = 2'd1; look();
        chk("R10 select 3 write leaves enable", rd_data, 8'h02);
        step(); rd_sel = 2'd0; look();
        chk("R10 select 3 write leaves status", rd_data, 8'h00);

        // R4 suspend threshold (activity first to start a fresh count)
        step(); bus_active = 1'b1; step(); bus_active = 1'b0; tick = 1'b1;
        repeat (IDLE) step();
        look(); chk("R4 suspend clear after IDLE ticks", rd_data, 8'h00);
        step(); look(); chk("R4 suspend set after IDLE+1 ticks", rd_data, 8'h08);

        // R5 once per idle period
        step();
        wr(2'd0, 8'h08);
        repeat (3 * IDLE) step();
        look(); chk("R5 no second suspend without activity", rd_data, 8'h00);
        step();
        bus_active = 1'b1; step(); bus_active = 1'b0;
        repeat (IDLE / 2) step();
        bus_active = 1'b1; step(); bus_active = 1'b0;
        repeat (IDLE) step();
        look(); chk("R5 activity restarts idle count", rd_data, 8'h00);
        step(); look(); chk("R5 suspend after restart", rd_data, 8'h08);
        step(); tick = 1'b0;

        // random phase compared with the model every cycle
        for (int i = 0; i < 3000; i++) begin
            bus_active  = (($urandom % 16) == 0);
            tick        = (($urandom % 2) == 0);
            ep0_rx_done = (($urandom % 8) == 0);
            ep0_tx_done = (($urandom % 8) == 0);
            ep1_tx_done = (($urandom % 8) == 0);
            resume_det  = (($urandom % 16) == 0);
            wr_en       = (($urandom % 4) == 0);
            wr_sel      = 2'($urandom % 4);
            wr_data     = 8'($urandom);
            rd_sel      = 2'($urandom % 4);
            step();
        end
        bus_active = 1'b0; tick = 1'b0; ep0_rx_done = 1'b0; ep0_tx_done = 1'b0;
        ep1_tx_done = 1'b0; resume_det = 1'b0; wr_en = 1'b0;
        step(); look();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule